// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a 32-bit processor with fixed-width instructions and works out, every cycle, where fetch goes next. It takes the instruction fetched at the current PC and two register operand values, which a register file outside the block supplies. It decodes the opcode and the immediate fields itself. It then picks one of three addresses: the incremented PC, a PC-relative branch target, or a region-local jump target.

There are two conditional branches. One is taken when the operands match and the other when they differ. Their offset counts words relative to the incremented PC and may point backward. The two jumps keep the top address bits of the incremented PC and replace the rest with the instruction's 26-bit target field scaled to bytes. The linking jump also presents the return address. A stall input freezes the PC register while the computed next address stays visible.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) sets pc to 0.
- R2: For any opcode (instr[31:26]) other than 0x02, 0x03, 0x04 and 0x05, next_pc equals pc + 4.
- R3: For opcode 0x04, next_pc is pc + 4 + sext(instr[15:0]) * 4 when rs_val equals rt_val, and pc + 4 otherwise.
- R4: For opcode 0x05, next_pc is pc + 4 + sext(instr[15:0]) * 4 when rs_val differs from rt_val, and pc + 4 otherwise.
- R5: The 16-bit branch offset is a two's-complement value, so offsets with bit 15 set move the target below pc + 4, down to 0x8000 words back.
- R6: For opcode 0x02, next_pc is {(pc + 4)[31:28], instr[25:0], 2'b00}; the top nibble comes from the incremented PC even when that differs from pc[31:28].
- R7: Opcode 0x03 produces the same target as R6 and also drives link_valid high with link_addr = pc + 4. For every other opcode link_valid is low.
- R8: While stall is high at a rising edge, pc keeps its value, and next_pc still reflects the current inputs.
- R9: At each rising edge with rst_n high and stall low, pc takes the next_pc value presented before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Holds the PC register when high |
| instr | input | 32 | Instruction fetched at pc |
| rs_val | input | 32 | First register operand value |
| rt_val | input | 32 | Second register operand value |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address to be loaded at the next unstalled edge |
| link_addr | output | 32 | Return address for the linking jump |
| link_valid | output | 1 | High when instr is the linking jump |

## Verification
The assertions assume that instr, rs_val, rt_val and stall are stable and known around each rising edge. They also assume that rst_n is driven low from time zero, so that the first sampled PC is a reset value. The bench changes inputs just after a rising edge and reads outputs a full half period before the next one. It holds reset from the start. It reaches PC values only through the block's own jumps and branches, so the PC it models is always one the design can hold. This includes the 0x0FFFFFFC address, where the incremented PC crosses into the next 256 MB region.

// File: rtl/npc_pkg.sv
package npc_pkg;

   // Kinds of control flow the unit distinguishes
   typedef enum logic [1:0] {
      FLOW_SEQ  = 2'd0,
      FLOW_BR   = 2'd1,
      FLOW_JUMP = 2'd2
   } flow_e;

   // Decoded view of one instruction word
   typedef struct packed {
      flow_e flow;
      logic  br_on_ne;   // branch taken on inequality instead of equality
      logic  link;       // jump also produces a return address
   } npc_dec_t;

   // Default opcode values
   localparam logic [5:0] OPC_JUMP_DEF  = 6'h02;
   localparam logic [5:0] OPC_JLINK_DEF = 6'h03;
   localparam logic [5:0] OPC_BREQ_DEF  = 6'h04;
   localparam logic [5:0] OPC_BRNE_DEF  = 6'h05;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int unsigned OPC_W     = 6,
   parameter logic [OPC_W-1:0] OP_BREQ  = OPC_BREQ_DEF,
   parameter logic [OPC_W-1:0] OP_BRNE  = OPC_BRNE_DEF,
   parameter logic [OPC_W-1:0] OP_JUMP  = OPC_JUMP_DEF,
   parameter logic [OPC_W-1:0] OP_JLINK = OPC_JLINK_DEF
) (
   input  logic [OPC_W-1:0] opcode,
   output npc_dec_t         dec
);

   always_comb begin
      dec.flow     = FLOW_SEQ;
      dec.br_on_ne = 1'b0;
      dec.link     = 1'b0;
      if (opcode == OP_BREQ) begin
         dec.flow = FLOW_BR;
      end else if (opcode == OP_BRNE) begin
         dec.flow     = FLOW_BR;
         dec.br_on_ne = 1'b1;
      end else if (opcode == OP_JUMP) begin
         dec.flow = FLOW_JUMP;
      end else if (opcode == OP_JLINK) begin
         dec.flow = FLOW_JUMP;
         dec.link = 1'b1;
      end
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          XOR_REDUCE = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              is_branch,
   input  logic              on_ne,
   output logic              taken
);

   logic same;

   generate
      if (XOR_REDUCE) begin : g_xor
         logic [DATA_W-1:0] diff;
         assign diff = op_a ^ op_b;
         assign same = ~|diff;
      end else begin : g_eq
         assign same = (op_a == op_b);
      end
   endgenerate

   assign taken = is_branch & (same ^ on_ne);

endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned JF_W    = 26,
   parameter int unsigned STEP    = 4
) (
   input  logic [ADDR_W-1:0]  pc,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  pc_inc,
   output logic [ADDR_W-1:0]  br_tgt,
   output logic [ADDR_W-1:0]  jmp_tgt
);

   localparam int unsigned SHIFT  = $clog2(STEP);
   localparam int unsigned EXT_W  = ADDR_W - OFF_W - SHIFT;
   localparam int unsigned KEEP_W = ADDR_W - JF_W - SHIFT;

   logic [OFF_W-1:0]  off_f;
   logic [JF_W-1:0]   jmp_f;
   logic [ADDR_W-1:0] off_bytes;

   assign off_f = instr[OFF_W-1:0];
   assign jmp_f = instr[JF_W-1:0];

   assign pc_inc    = pc + ADDR_W'(STEP);
   assign off_bytes = {{EXT_W{off_f[OFF_W-1]}}, off_f, {SHIFT{1'b0}}};
   assign br_tgt    = pc_inc + off_bytes;
   assign jmp_tgt   = {pc_inc[ADDR_W-1 -: KEEP_W], jmp_f, {SHIFT{1'b0}}};

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INSTR_W    = 32,
   parameter int unsigned OPC_W      = 6,
   parameter int unsigned OFF_W      = 16,
   parameter int unsigned JF_W       = 26,
   parameter int unsigned STEP       = 4,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter bit          XOR_REDUCE = 1'b1,
   parameter bit          LINK_EN    = 1'b1,
   parameter logic [OPC_W-1:0] OP_BREQ  = OPC_BREQ_DEF,
   parameter logic [OPC_W-1:0] OP_BRNE  = OPC_BRNE_DEF,
   parameter logic [OPC_W-1:0] OP_JUMP  = OPC_JUMP_DEF,
   parameter logic [OPC_W-1:0] OP_JLINK = OPC_JLINK_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  rs_val,
   input  logic [ADDR_W-1:0]  rt_val,
   output logic [ADDR_W-1:0]  pc,
   output logic [ADDR_W-1:0]  next_pc,
   output logic [ADDR_W-1:0]  link_addr,
   output logic               link_valid
);

   localparam int unsigned SHIFT = $clog2(STEP);

   // Elaboration-time parameter checks
   generate
      if ((1 << SHIFT) != STEP) begin : g_bad_step
         $error("npc_unit: STEP must be a power of two");
      end
      if (OPC_W + JF_W != INSTR_W) begin : g_bad_jfield
         $error("npc_unit: opcode and jump field must fill the instruction");
      end
      if (OFF_W + SHIFT >= ADDR_W) begin : g_bad_off
         $error("npc_unit: branch offset too wide for address");
      end
      if (JF_W + SHIFT >= ADDR_W) begin : g_bad_jw
         $error("npc_unit: jump field leaves no region bits");
      end
   endgenerate

   npc_dec_t          dec;
   logic              br_taken;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] jmp_tgt;
   logic [ADDR_W-1:0] pc_q;

   npc_decode #(
      .OPC_W   (OPC_W),
      .OP_BREQ (OP_BREQ),
      .OP_BRNE (OP_BRNE),
      .OP_JUMP (OP_JUMP),
      .OP_JLINK(OP_JLINK)
   ) u_dec (
      .opcode(instr[INSTR_W-1 -: OPC_W]),
      .dec   (dec)
   );

   npc_cond #(
      .DATA_W    (ADDR_W),
      .XOR_REDUCE(XOR_REDUCE)
   ) u_cond (
      .op_a     (rs_val),
      .op_b     (rt_val),
      .is_branch(dec.flow == FLOW_BR),
      .on_ne    (dec.br_on_ne),
      .taken    (br_taken)
   );

   npc_target #(
      .ADDR_W (ADDR_W),
      .INSTR_W(INSTR_W),
      .OFF_W  (OFF_W),
      .JF_W   (JF_W),
      .STEP   (STEP)
   ) u_tgt (
      .pc     (pc_q),
      .instr  (instr),
      .pc_inc (pc_inc),
      .br_tgt (br_tgt),
      .jmp_tgt(jmp_tgt)
   );

   always_comb begin
      if (dec.flow == FLOW_JUMP) begin
         next_pc = jmp_tgt;
      end else if (br_taken) begin
         next_pc = br_tgt;
      end else begin
         next_pc = pc_inc;
      end
   end

   generate
      if (LINK_EN) begin : g_link
         assign link_valid = dec.link;
         assign link_addr  = pc_inc;
      end else begin : g_nolink
         assign link_valid = 1'b0;
         assign link_addr  = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
      end else if (!stall) begin
         pc_q <= next_pc;
      end
   end

   assign pc = pc_q;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OPC_W   = 6,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned JF_W    = 26,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter logic [OPC_W-1:0] OP_BREQ  = 6'h04,
   parameter logic [OPC_W-1:0] OP_BRNE  = 6'h05,
   parameter logic [OPC_W-1:0] OP_JUMP  = 6'h02,
   parameter logic [OPC_W-1:0] OP_JLINK = 6'h03
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stall,
   input logic [INSTR_W-1:0] instr,
   input logic [ADDR_W-1:0]  rs_val,
   input logic [ADDR_W-1:0]  rt_val,
   input logic [ADDR_W-1:0]  pc,
   input logic [ADDR_W-1:0]  next_pc,
   input logic [ADDR_W-1:0]  link_addr,
   input logic               link_valid
);

   localparam int unsigned KEEP_W = ADDR_W - JF_W - 2;

   logic [OPC_W-1:0]  opc;
   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] boff;
   logic              is_ctl;

   assign opc    = instr[INSTR_W-1 -: OPC_W];
   assign inc    = pc + ADDR_W'(4);
   assign boff   = ADDR_W'($signed(instr[OFF_W-1:0])) << 2;
   assign is_ctl = (opc == OP_BREQ) || (opc == OP_BRNE) ||
                   (opc == OP_JUMP) || (opc == OP_JLINK);

   assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> pc == RESET_PC);

   assert_seq_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !is_ctl |-> next_pc == inc);

   assert_beq_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OP_BREQ && rs_val == rt_val) |-> next_pc == inc + boff);

   assert_bne_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OP_BRNE && rs_val != rt_val) |-> next_pc == inc + boff);

   assert_jump_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OP_JUMP || opc == OP_JLINK) |->
         (next_pc[ADDR_W-1 -: KEEP_W] == inc[ADDR_W-1 -: KEEP_W] &&
          next_pc[1:0] == 2'b00));

   assert_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid |-> (opc == OP_JLINK && link_addr == inc));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> pc == $past(pc));

   assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> pc == $past(next_pc));

endmodule

bind npc_unit npc_unit_chk #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W),
   .OPC_W   (OPC_W),
   .OFF_W   (OFF_W),
   .JF_W    (JF_W),
   .RESET_PC(RESET_PC),
   .OP_BREQ (OP_BREQ),
   .OP_BRNE (OP_BRNE),
   .OP_JUMP (OP_JUMP),
   .OP_JLINK(OP_JLINK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stall     (stall),
   .instr     (instr),
   .rs_val    (rs_val),
   .rt_val    (rt_val),
   .pc        (pc),
   .next_pc   (next_pc),
   .link_addr (link_addr),
   .link_valid(link_valid)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc, next_pc, link_addr;
   logic        link_valid;

   int n_run  = 0;
   int n_fail = 0;
   logic [31:0] exp_pc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_unit uut (
      .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .next_pc(next_pc),
      .link_addr(link_addr), .link_valid(link_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Arithmetic reference for the next address
   function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] ins,
                                          input logic [31:0] a, input logic [31:0] b);
      logic [31:0] p4;
      int          off;
      p4  = p + 32'd4;
      off = int'($signed(ins[15:0]));
      case (ins[31:26])
         6'h04: model = (a == b) ? p4 + 32'(off * 4) : p4;
         6'h05: model = (a != b) ? p4 + 32'(off * 4) : p4;
         6'h02, 6'h03: model = (p4 & 32'hF000_0000) | (32'(ins[25:0]) * 32'd4);
         default: model = p4;
      endcase
   endfunction

   function automatic string tag_of(input logic [31:0] ins);
      case (ins[31:26])
         6'h04: tag_of = "R3";
         6'h05: tag_of = "R4";
         6'h02: tag_of = "R6";
         6'h03: tag_of = "R7";
         default: tag_of = "R2";
      endcase
   endfunction

   // Drive one instruction, check combinational outputs, clock, check pc.
   // Called half a period or more before a rising edge.
   task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic st, input string req);
      logic [31:0] e;
      instr  = ins;
      rs_val = a;
      rt_val = b;
      stall  = st;
      #1;
      e = model(exp_pc, ins, a, b);
      check(req, next_pc, e);
      check("R7", {31'd0, link_valid}, {31'd0, ins[31:26] == 6'h03});
      if (ins[31:26] == 6'h03) check("R7", link_addr, exp_pc + 32'd4);
      @(posedge clk);
      #1;
      if (!st) exp_pc = e;
      check(st ? "R8" : "R9", pc, exp_pc);
   endtask

   task automatic jump_to(input logic [25:0] f);
      step({6'h02, f}, 32'd0, 32'd0, 1'b0, "R6");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] offs [8];
      offs = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
               16'hFFFF, 16'hFFFE, 16'h8000, 16'hC123};

      // R1: reset
      repeat (3) @(posedge clk);
      #1;
      check("R1", pc, 32'd0);
      rst_n = 1'b1;
      exp_pc = 32'd0;

      // R2..R7: every opcode value with matching and differing operands
      for (int op = 0; op < 64; op++) begin
         step({6'(op), 5'd3, 5'd7, 16'h0010}, 32'h55, 32'h55, 1'b0, tag_of({6'(op), 26'd0}));
         step({6'(op), 5'd1, 5'd2, 16'hFFF0}, 32'h55, 32'hAA, 1'b0, tag_of({6'(op), 26'd0}));
      end

      // Worked examples: j 20000 -> 80000, bne at 80012 offset 2 -> 80024
      jump_to(26'd20000);
      check("R6", pc, 32'd80000);
      jump_to(26'd20003);
      step({6'h05, 5'd8, 5'd21, 16'd2}, 32'd1, 32'd9, 1'b0, "R4");
      check("R4", pc, 32'd80024);

      // Branch sweep: both kinds, equal and unequal operands, varied offsets
      for (int k = 0; k < 8; k++) begin
         for (int kind = 0; kind < 2; kind++) begin
            for (int eq = 0; eq < 2; eq++) begin
               jump_to(26'h0100000);
               step({(kind == 0) ? 6'h04 : 6'h05, 10'd0, offs[k]},
                    32'hDEAD_0000, (eq != 0) ? 32'hDEAD_0000 : 32'hDEAD_0001, 1'b0,
                    offs[k][15] ? "R5" : ((kind == 0) ? "R3" : "R4"));
            end
         end
      end
      // R5: most negative offset lands 0x20000 bytes below pc+4
      jump_to(26'h0100000);
      step({6'h04, 10'd0, 16'h8000}, 32'd5, 32'd5, 1'b0, "R5");
      check("R5", pc, 32'h0040_0004 - 32'h0002_0000);

      // R6/R7: region boundary, top nibble from incremented pc
      jump_to(26'h3FF_FFFF);
      check("R6", pc, 32'h0FFF_FFFC);
      step({6'h03, 26'd5}, 32'd0, 32'd0, 1'b0, "R7");
      check("R7", pc, 32'h1000_0014);
      jump_to(26'h3FF_FFFF);
      check("R6", pc, 32'h1FFF_FFFC);
      jump_to(26'd0);
      check("R6", pc, 32'h2000_0000);

      // R8: stall holds pc while next_pc follows the inputs
      step({6'h02, 26'd77}, 32'd0, 32'd0, 1'b1, "R8");
      step({6'h05, 10'd0, 16'd9}, 32'd1, 32'd2, 1'b1, "R8");
      step({6'h00, 26'd0}, 32'd0, 32'd0, 1'b1, "R8");
      check("R8", pc, 32'h2000_0000);
      step({6'h00, 26'd0}, 32'd0, 32'd0, 1'b0, "R9");

      // R1: reset during operation
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R1", pc, 32'd0);
      rst_n = 1'b1;
      exp_pc = 32'd0;
      step({6'h3F, 26'd0}, 32'd0, 32'd0, 1'b0, "R2");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule